// File: doc/BRIEF.md
# Scrambled RAM Rekey and Fill Sequencer

This block coordinates two operations that software starts on a scrambled on-chip RAM. The first is a key refresh. The block raises a request to an external key source and holds it until an acknowledge returns a new key together with a nonce. The second is a memory fill. The block writes pseudo-random words to every address of the array. The words come from a Galois LFSR whose seed is taken from the low bits of the most recently captured nonce.

The two operations exclude each other. A key refresh cannot start while a fill is pending. A second refresh cannot start while one is outstanding. A second fill request cannot restart a fill that is already running. When one control write asks for both operations, the key refresh runs first. The fill is held pending until the acknowledge arrives and then seeds itself from the new nonce. While the key is invalid or a fill is in progress, the block raises a gate that holds off normal RAM traffic.

Top module: `scram_init_seq`

## Requirements
- R1: A rekey write (`rekey_we_i` high with `rekey_bit_i` = 1) is accepted only if no key request is outstanding and no fill is pending. Any other rekey write leaves `key_req_o` and `key_valid_o` unchanged.
- R2: A fill write (`init_we_i` high with `init_bit_i` = 1) is accepted only if no fill is pending. A fill write during a running fill does not change the address or data sequence of that fill.
- R3: `key_req_o` rises in the cycle after an accepted rekey and stays high until the cycle after `key_ack_i` is sampled high. An acknowledge seen while no request is outstanding has no effect.
- R4: `key_valid_o` is 0 after reset. It drops in the cycle after a rekey is accepted and rises in the cycle after the acknowledge. The acknowledge also captures `key_nonce_i`.
- R5: `ram_block_o` is high whenever `key_valid_o` is 0 or `init_busy_o` is 1, and low otherwise.
- R6: The fill seed is bits [LFSR_W-1:0] of the captured nonce, replaced by 1 if that slice is zero. The seed loads one cycle after the fill is accepted (or one cycle after the acknowledge if the fill was deferred). The first word is written in the cycle after that.
- R7: Word k of a fill goes to address k, for k = 0 up to DEPTH-1. Its data is the seed advanced k times by a right-shifting Galois step: shift right by one, then XOR with 16'hB400 if the bit shifted out was 1. At most one word is written per cycle, and only while `mem_ready_i` is high. A stall holds the address and the data.
- R8: In the cycle after the last address is written, `init_busy_o` falls and `init_done_o` rises. `init_done_o` clears in the cycle after a new fill is accepted.
- R9: If one write asks for both operations, the key request is issued first and no memory write occurs while it is outstanding. The fill then uses the nonce delivered by that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rekey_we_i | input | 1 | Write qualifier for the rekey control bit |
| rekey_bit_i | input | 1 | Rekey control bit value |
| init_we_i | input | 1 | Write qualifier for the fill control bit |
| init_bit_i | input | 1 | Fill control bit value |
| key_ack_i | input | 1 | Acknowledge from the key source |
| key_nonce_i | input | NONCE_W | Nonce delivered with the acknowledge |
| mem_ready_i | input | 1 | Memory can take a fill write this cycle |
| key_req_o | output | 1 | Key request to the key source |
| mem_we_o | output | 1 | Fill write strobe |
| mem_addr_o | output | ADDR_W | Fill write address |
| mem_wdata_o | output | LFSR_W | Fill write data |
| key_valid_o | output | 1 | Key-valid status |
| init_busy_o | output | 1 | Fill pending or running |
| init_done_o | output | 1 | Fill completed |
| ram_block_o | output | 1 | Gate that holds off normal RAM traffic |

## Verification
The hardest case to reach is a fill request that arrives in the same write as a rekey. The fill must stay pending without writing, through an acknowledge delay of several cycles. It must then take its seed from the nonce that was just delivered, not from the older one. The bench creates this case by asserting both write qualifiers in one cycle and delaying the acknowledge. It changes the nonce between runs so that a stale seed would produce a different first word. The lockout cases are reached the same way. A repeated fill write and a rekey write are injected halfway through a running fill, and the complete word sequence is compared against an independently computed LFSR model.

// File: rtl/scram_seq_pkg.sv
package scram_seq_pkg;

  // Right-shifting Galois feedback masks giving maximal-length sequences.
  function automatic logic [63:0] galois_mask(input int unsigned width);
    case (width)
      8:       return 64'h0000_00B8;
      16:      return 64'h0000_B400;
      24:      return 64'h00E1_0000;
      32:      return 64'hA300_0000;
      default: return 64'h0000_B400;
    endcase
  endfunction

endpackage

// File: rtl/scram_key_tracker.sv
module scram_key_tracker #(
  parameter int unsigned NONCE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  logic               ack_i,
  input  logic [NONCE_W-1:0] nonce_i,
  output logic               pending_o,
  output logic               valid_o,
  output logic [NONCE_W-1:0] nonce_o,
  output logic               ack_ev_o
);
  logic pend_q, valid_q;
  logic [NONCE_W-1:0] nonce_q;

  assign ack_ev_o = ack_i & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
      nonce_q <= '0;
    end else begin
      if (accept_i) begin
        pend_q  <= 1'b1;
        valid_q <= 1'b0;
      end else if (ack_ev_o) begin
        pend_q  <= 1'b0;
        valid_q <= 1'b1;
        nonce_q <= nonce_i;
      end
    end
  end

  assign pending_o = pend_q;
  assign valid_o   = valid_q;
  assign nonce_o   = nonce_q;
endmodule

// File: rtl/scram_fill_lfsr.sv
module scram_fill_lfsr
  import scram_seq_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  localparam logic [63:0]  MASK64 = galois_mask(W);
  localparam logic [W-1:0] MASK   = MASK64[W-1:0];

  function automatic logic [W-1:0] advance(input logic [W-1:0] s);
    return (s >> 1) ^ (s[0] ? MASK : '0);
  endfunction

  function automatic logic [W-1:0] fix_seed(input logic [W-1:0] s);
    return (s == '0) ? W'(1) : s;
  endfunction

  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= W'(1);
    else if (load_i) state_q <= fix_seed(seed_i);
    else if (step_i) state_q <= advance(state_q);
  end

  assign state_o = state_q;
endmodule

// File: rtl/scram_fill_ctrl.sv
module scram_fill_ctrl #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              key_busy_i,
  input  logic              mem_ready_i,
  output logic              busy_o,
  output logic              seed_load_o,
  output logic              write_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_write_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic busy_q, need_seed_q, done_q;
  logic [ADDR_W-1:0] addr_q;

  assign seed_load_o  = need_seed_q & ~key_busy_i;
  assign write_o      = busy_q & ~need_seed_q & ~key_busy_i & mem_ready_i;
  assign last_write_o = write_o & (addr_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      need_seed_q <= 1'b0;
      done_q      <= 1'b0;
      addr_q      <= '0;
    end else begin
      // completion wins over a new start
      if (last_write_o)  busy_q <= 1'b0;
      else if (start_i)  busy_q <= 1'b1;

      if (start_i)          need_seed_q <= 1'b1;
      else if (seed_load_o) need_seed_q <= 1'b0;

      if (start_i)           done_q <= 1'b0;
      else if (last_write_o) done_q <= 1'b1;

      if (seed_load_o)                  addr_q <= '0;
      else if (write_o && !last_write_o) addr_q <= addr_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign addr_o = addr_q;
  assign done_o = done_q;
endmodule

// File: rtl/scram_init_seq.sv
module scram_init_seq #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned LFSR_W  = 16,
  parameter int unsigned NONCE_W = 32,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rekey_we_i,
  input  logic               rekey_bit_i,
  input  logic               init_we_i,
  input  logic               init_bit_i,
  input  logic               key_ack_i,
  input  logic [NONCE_W-1:0] key_nonce_i,
  input  logic               mem_ready_i,
  output logic               key_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [LFSR_W-1:0]  mem_wdata_o,
  output logic               key_valid_o,
  output logic               init_busy_o,
  output logic               init_done_o,
  output logic               ram_block_o
);
  // named internal events, visible to the bound checker
  logic rekey_acc_ev, init_acc_ev, ack_ev, seed_load_ev, fill_step_ev, fill_last_ev;
  logic key_pend, key_valid, fill_busy;
  logic [NONCE_W-1:0] nonce_q;

  assign rekey_acc_ev = rekey_we_i & rekey_bit_i & ~key_pend & ~fill_busy;
  assign init_acc_ev  = init_we_i & init_bit_i & ~fill_busy;

  scram_key_tracker #(.NONCE_W(NONCE_W)) u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (rekey_acc_ev),
    .ack_i     (key_ack_i),
    .nonce_i   (key_nonce_i),
    .pending_o (key_pend),
    .valid_o   (key_valid),
    .nonce_o   (nonce_q),
    .ack_ev_o  (ack_ev)
  );

  scram_fill_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (init_acc_ev),
    .key_busy_i   (key_pend),
    .mem_ready_i  (mem_ready_i),
    .busy_o       (fill_busy),
    .seed_load_o  (seed_load_ev),
    .write_o      (fill_step_ev),
    .addr_o       (mem_addr_o),
    .last_write_o (fill_last_ev),
    .done_o       (init_done_o)
  );

  scram_fill_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (seed_load_ev),
    .seed_i  (nonce_q[LFSR_W-1:0]),
    .step_i  (fill_step_ev),
    .state_o (mem_wdata_o)
  );

  assign key_req_o   = key_pend;
  assign key_valid_o = key_valid;
  assign init_busy_o = fill_busy;
  assign mem_we_o    = fill_step_ev;
  assign ram_block_o = ~key_valid | fill_busy;
endmodule

// File: rtl/scram_init_seq_chk.sv
module scram_init_seq_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LFSR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              key_ack_i,
  input logic              key_req_o,
  input logic              key_valid_o,
  input logic              init_busy_o,
  input logic              init_done_o,
  input logic              ram_block_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [LFSR_W-1:0] mem_wdata_o,
  input logic              seed_load_ev
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  assert_lockout_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_busy_o && !key_req_o |=> !key_req_o);
  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_req_o && !key_ack_i |=> key_req_o);
  assert_req_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_req_o && key_ack_i |=> !key_req_o);
  assert_valid_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_req_o && key_ack_i |=> key_valid_o);
  assert_valid_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(key_req_o) |-> !key_valid_o);
  assert_fill_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ram_block_o);
  assert_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wdata_o != '0);
  assert_addr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && mem_addr_o != LAST |=> mem_addr_o == $past(mem_addr_o) + 1'b1);
  assert_addr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_busy_o && !mem_we_o && !seed_load_ev |=> $stable(mem_addr_o) && $stable(mem_wdata_o));
  assert_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && mem_addr_o == LAST |=> init_done_o && !init_busy_o);
  assert_order_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_req_o |-> !mem_we_o);
endmodule

bind scram_init_seq scram_init_seq_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LFSR_W(LFSR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .key_ack_i    (key_ack_i),
  .key_req_o    (key_req_o),
  .key_valid_o  (key_valid_o),
  .init_busy_o  (init_busy_o),
  .init_done_o  (init_done_o),
  .ram_block_o  (ram_block_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .seed_load_ev (seed_load_ev)
);

// File: tb/scram_init_seq_tb.sv
module scram_init_seq_tb;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rekey_we = 0, rekey_bit = 1, init_we = 0, init_bit = 1, key_ack = 0, mem_ready = 1;
  logic [31:0] key_nonce = '0;
  logic key_req, mem_we, key_valid, init_busy, init_done, ram_block;
  logic [3:0] mem_addr;
  logic [15:0] mem_wdata;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  scram_init_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rekey_we_i(rekey_we), .rekey_bit_i(rekey_bit),
    .init_we_i(init_we), .init_bit_i(init_bit),
    .key_ack_i(key_ack), .key_nonce_i(key_nonce), .mem_ready_i(mem_ready),
    .key_req_o(key_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .key_valid_o(key_valid), .init_busy_o(init_busy), .init_done_o(init_done),
    .ram_block_o(ram_block)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_next(input logic [15:0] s);
    logic [15:0] n;
    n = {1'b0, s[15:1]};
    if (s[0]) n = n ^ 16'hB400;
    return n;
  endfunction

  function automatic logic [15:0] model_seed(input logic [31:0] n);
    return (n[15:0] == 16'h0) ? 16'h0001 : n[15:0];
  endfunction

  task automatic write_ctrl(input logic rk, input logic in);
    @(negedge clk);
    rekey_we = rk; init_we = in;
    @(negedge clk);
    rekey_we = 0; init_we = 0;
  endtask

  task automatic give_ack(input logic [31:0] n);
    @(negedge clk);
    key_ack = 1; key_nonce = n;
    @(negedge clk);
    key_ack = 0;
  endtask

  // mode 0 plain, 1 repeat init mid-run, 2 rekey mid-run, 3 stalls
  task automatic run_fill(input logic [15:0] seed, input int mode, input string req);
    logic [15:0] exp_d;
    int k;
    bit req_seen, block_low, seq_bad;
    exp_d = seed; k = 0; req_seen = 0; block_low = 0; seq_bad = 0;
    for (int cyc = 0; cyc < 6 * DEPTH + 20; cyc++) begin
      init_we   = (mode == 1 && cyc == 6);
      rekey_we  = (mode == 2 && cyc == 6);
      mem_ready = (mode == 3) ? (cyc % 3 != 1) : 1'b1;
      #1;
      if (key_req) req_seen = 1;
      if (init_busy && !ram_block) block_low = 1;
      if (mem_we) begin
        if (mem_addr != k[3:0] || mem_wdata != exp_d) begin
          if (!seq_bad)
            chk(0, {req, " word"}, {mem_addr, mem_wdata}, {k[3:0], exp_d});
          seq_bad = 1;
        end
        exp_d = model_next(exp_d);
        k++;
      end
      if (!init_busy) break;
      @(negedge clk);
    end
    init_we = 0; rekey_we = 0; mem_ready = 1;
    chk(!seq_bad, {req, " R7 sequence"}, 0, 0);
    chk(k == DEPTH, {req, " R7 word count"}, k, DEPTH);
    chk(init_done && !init_busy, {req, " R8 done"}, {init_done, init_busy}, 2'b10);
    chk(!block_low, "R5 block during fill", block_low, 0);
    if (mode == 2) chk(!req_seen && key_valid, "R1 rekey ignored during fill", req_seen, 0);
  endtask

  task automatic t_reset();
    chk(!key_req && !key_valid && !init_busy && !init_done && !mem_we, "R4 reset state",
        {key_req, key_valid, init_busy, init_done, mem_we}, 0);
    chk(ram_block, "R5 block at reset", ram_block, 1);
    give_ack(32'h1111_2222);
    chk(!key_valid && !key_req, "R3 stray ack ignored", {key_valid, key_req}, 0);
  endtask

  task automatic t_rekey(input logic [31:0] n);
    write_ctrl(1, 0);
    chk(key_req, "R3 request raised", key_req, 1);
    chk(!key_valid && ram_block, "R4 valid cleared", {key_valid, ram_block}, 2'b01);
    write_ctrl(1, 0);
    chk(key_req, "R3 request held", key_req, 1);
    give_ack(n);
    chk(!key_req && key_valid, "R4 valid after ack", {key_req, key_valid}, 2'b01);
    chk(!ram_block, "R5 block released", ram_block, 0);
    @(negedge clk);
    chk(!key_req, "R1 repeated rekey not queued", key_req, 0);
  endtask

  task automatic t_fill(input logic [15:0] seed, input int mode, input string req);
    write_ctrl(0, 1);
    chk(init_busy && !init_done, {req, " R8 accept clears done"}, {init_busy, init_done}, 2'b10);
    chk(!mem_we, {req, " R6 no write before seed"}, mem_we, 0);
    run_fill(seed, mode, req);
    chk(!ram_block, {req, " R5 block after fill"}, ram_block, 0);
  endtask

  task automatic t_both(input logic [31:0] n);
    bit wrote;
    wrote = 0;
    write_ctrl(1, 1);
    chk(key_req && init_busy, "R9 both accepted", {key_req, init_busy}, 2'b11);
    chk(!init_done, "R8 done cleared", init_done, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (mem_we) wrote = 1;
    end
    chk(!wrote, "R9 no write while key outstanding", wrote, 0);
    give_ack(n);
    chk(!mem_we && init_busy, "R6 seed cycle after ack", {mem_we, init_busy}, 2'b01);
    run_fill(model_seed(n), 0, "R9");
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rekey(32'hDEAD_5A3C);
    t_fill(16'h5A3C, 0, "R6");
    t_fill(16'h5A3C, 1, "R2");
    t_fill(16'h5A3C, 2, "R1");
    t_both(32'h0BAD_C0DE);
    t_rekey(32'hFFFF_0000);
    t_fill(16'h0001, 3, "R6 zero");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule